// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block drives a two-wire programming and debug link: one clock line that it always owns, and one data line with its own output enable so that the target can drive it back. A host starts one operation at a time with a single-cycle start pulse that carries an operation code and a write byte. The block then produces a complete frame on the wire and reports the end of the frame with a one-cycle done pulse. A read byte and a timeout flag are valid with that pulse.

Each bit on the wire is one clock strobe: the clock goes low and then returns high. The data line is sampled after the rising edge that ends a strobe. The low and high times come from a divider value set by the host. Keeping the low time short matters, because the target reads a long low time as a reset. The block uses exactly that to produce its separate reset operation.

There are four single-byte frame kinds: address write, address read, data write and data read. Data frames include an open-ended wait phase. In that phase the master polls the target until the target drives data high, and it gives up after a fixed number of attempts.

Top module: `twd_master`

## Requirements
- R1: After reset and whenever no operation is running, ck_o is 1, d_oe_o is 0, busy_o is 0 and done_o is 0.
- R2: Every frame starts with one strobe with d_oe_o=0. Two instruction strobes follow with d_oe_o=1, carrying op_i[0] and then op_i[1]. op_i values 0, 1, 2 and 3 select data read, data write, address read and address write. Any op_i with bit 2 set selects target reset.
- R3: An address write drives wdata_i LSB first on 8 strobes, then one STOP strobe with the line released: 12 strobes in total.
- R4: An address read releases the line for 8 strobes and samples d_i after each one, LSB first, into rdata_o. One STOP strobe follows: 12 strobes in total.
- R5: Data frames send two length strobes driven 0 directly after the instruction.
- R6: A data write drives 8 data bits LSB first, then a wait phase, then a released STOP strobe.
- R7: A data read runs the wait phase, then samples 8 bits LSB first into rdata_o, then a released STOP strobe.
- R8: The wait phase issues released strobes until d_i is sampled high. A high sample on any of the first 20 attempts ends the phase without an error.
- R9: If d_i is still low after the 20th wait strobe, the frame ends with done_o and err_o both 1. No STOP strobe is sent and rdata_o is left unchanged.
- R10: A frame strobe keeps ck_o low for exactly div_i+1 clocks. It then keeps ck_o high for at least div_i+1 clocks before the next strobe.
- R11: A target reset is a single low pulse of 25*(div_i+1) clocks with d_oe_o=0. It is followed by div_i+1 high clocks and then done_o.
- R12: busy_o is high from the clock after an accepted start until done_o. A start pulse while busy_o is high has no effect on the frame.
- R13: done_o is high for exactly one clock. err_o is never high without done_o.
- R14: d_o and d_oe_o settle at least one clock before ck_o falls and hold steady while ck_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle operation request |
| op_i | input | 3 | Operation code |
| wdata_i | input | 8 | Byte for write frames |
| div_i | input | DIV_W | Strobe phase length minus one, in clocks |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Wait timeout, valid with done_o |
| rdata_o | output | 8 | Byte from the last read frame |
| ck_o | output | 1 | Link clock line |
| d_o | output | 1 | Data line output value |
| d_oe_o | output | 1 | Data line output enable |
| d_i | input | 1 | Data line input |

## Verification
The bench behaves as a target model. Random operations, bytes, divider values and wait stall counts are applied, and for each one the bench rebuilds the expected strobe sequence. It then compares that sequence strobe by strobe with what appeared on the wire. Because instruction, length, data and wait bits are each compared at their own positions, a swapped bit order, a missing length field or a misplaced wait phase shows up as a distinct mismatch. Directed cases set the stall count to 19, which must still succeed on the last attempt, and to 20, which must time out without a STOP strobe. Further directed cases use the smallest divider and send a second start while a frame is running. Measuring how long the clock stays low separates normal strobes from the reset pulse.

// File: rtl/twd_pkg.sv
package twd_pkg;
  typedef enum logic [3:0] {
    SL_IDLE, SL_START, SL_INS, SL_LEN, SL_WDAT,
    SL_RDAT, SL_WAIT, SL_STOP, SL_RST
  } slot_e;
endpackage

// File: rtl/twd_strobe.sv
module twd_strobe #(
  parameter int DIV_W      = 8,
  parameter int RST_PHASES = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             go_i,
  input  logic             long_i,
  output logic             ck_o,
  output logic             fin_o
);
  localparam int CNT_W = DIV_W + $clog2(RST_PHASES + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} ph_e;
  ph_e              ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per, low_len;

  assign per     = CNT_W'(div_i) + CNT_W'(1);
  assign low_len = long_i ? (per * CNT_W'(RST_PHASES)) - CNT_W'(1) : per - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      ck_o  <= 1'b1;
      fin_o <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q  <= PH_LOW;
          ck_o  <= 1'b0;
          cnt_q <= low_len;
        end
        PH_LOW: if (cnt_q == '0) begin
          ph_q  <= PH_HIGH;
          ck_o  <= 1'b1;
          cnt_q <= per - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_HIGH: if (cnt_q == '0) begin
          ph_q  <= PH_IDLE;
          fin_o <= 1'b1;
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/twd_seq.sv
module twd_seq
  import twd_pkg::*;
#(
  parameter int WAIT_TRIES = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] op_i,
  input  logic [7:0] wdata_i,
  input  logic       d_i,
  input  logic       fin_i,
  output logic       go_o,
  output logic       long_o,
  output logic       d_o,
  output logic       d_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [7:0] rdata_o
);
  localparam int TRY_W = $clog2(WAIT_TRIES + 1);

  slot_e            slot_q;
  logic [2:0]       bit_q;
  logic [TRY_W-1:0] try_q;
  logic [2:0]       op_q;
  logic [7:0]       wd_q;

  logic is_data, is_wr;
  assign is_data = ~op_q[1];
  assign is_wr   = op_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= SL_IDLE;
      bit_q   <= '0;
      try_q   <= '0;
      op_q    <= '0;
      wd_q    <= '0;
      go_o    <= 1'b0;
      long_o  <= 1'b0;
      d_o     <= 1'b0;
      d_oe_o  <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      go_o   <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (slot_q == SL_IDLE) begin
        if (start_i) begin
          op_q   <= op_i;
          wd_q   <= wdata_i;
          busy_o <= 1'b1;
          go_o   <= 1'b1;
          long_o <= op_i[2];
          d_oe_o <= 1'b0;
          d_o    <= 1'b0;
          slot_q <= op_i[2] ? SL_RST : SL_START;
        end
      end else if (fin_i) begin
        go_o   <= 1'b1;
        long_o <= 1'b0;
        unique case (slot_q)
          SL_START: begin
            slot_q <= SL_INS; bit_q <= '0; d_oe_o <= 1'b1; d_o <= op_q[0];
          end
          SL_INS: begin
            if (bit_q == 3'd0) begin
              bit_q <= 3'd1; d_o <= op_q[1];
            end else if (is_data) begin
              slot_q <= SL_LEN; bit_q <= '0; d_o <= 1'b0;
            end else if (is_wr) begin
              slot_q <= SL_WDAT; bit_q <= '0; d_o <= wd_q[0];
            end else begin
              slot_q <= SL_RDAT; bit_q <= '0; d_oe_o <= 1'b0; d_o <= 1'b0;
            end
          end
          SL_LEN: begin
            if (bit_q == 3'd0) begin
              bit_q <= 3'd1; d_o <= 1'b0;
            end else if (is_wr) begin
              slot_q <= SL_WDAT; bit_q <= '0; d_o <= wd_q[0];
            end else begin
              slot_q <= SL_WAIT; try_q <= '0; d_oe_o <= 1'b0; d_o <= 1'b0;
            end
          end
          SL_WDAT: begin
            if (bit_q == 3'd7) begin
              slot_q <= is_data ? SL_WAIT : SL_STOP;
              try_q  <= '0; d_oe_o <= 1'b0; d_o <= 1'b0;
            end else begin
              bit_q <= bit_q + 3'd1; d_o <= wd_q[bit_q + 3'd1];
            end
          end
          SL_RDAT: begin
            rdata_o <= {d_i, rdata_o[7:1]};
            if (bit_q == 3'd7) slot_q <= SL_STOP;
            else               bit_q  <= bit_q + 3'd1;
          end
          SL_WAIT: begin
            if (d_i) begin
              bit_q  <= '0;
              slot_q <= is_wr ? SL_STOP : SL_RDAT;
            end else if (try_q == TRY_W'(WAIT_TRIES - 1)) begin
              // give up: no STOP strobe
              go_o <= 1'b0; done_o <= 1'b1; err_o <= 1'b1;
              busy_o <= 1'b0; slot_q <= SL_IDLE;
            end else try_q <= try_q + TRY_W'(1);
          end
          default: begin // SL_STOP, SL_RST
            go_o <= 1'b0; done_o <= 1'b1; busy_o <= 1'b0;
            slot_q <= SL_IDLE; d_oe_o <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/twd_master.sv
module twd_master #(
  parameter int DIV_W      = 8,
  parameter int RST_PHASES = 25,
  parameter int WAIT_TRIES = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [7:0]       wdata_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [7:0]       rdata_o,
  output logic             ck_o,
  output logic             d_o,
  output logic             d_oe_o,
  input  logic             d_i
);
  logic go, long_pulse, fin;

  twd_strobe #(.DIV_W(DIV_W), .RST_PHASES(RST_PHASES)) u_strobe (
    .clk_i, .rst_ni, .div_i, .go_i(go), .long_i(long_pulse), .ck_o, .fin_o(fin)
  );

  twd_seq #(.WAIT_TRIES(WAIT_TRIES)) u_seq (
    .clk_i, .rst_ni, .start_i, .op_i, .wdata_i, .d_i, .fin_i(fin),
    .go_o(go), .long_o(long_pulse), .d_o, .d_oe_o, .busy_o, .done_o,
    .err_o, .rdata_o
  );
endmodule

// File: rtl/twd_master_chk.sv
module twd_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic ck_o,
  input logic d_o,
  input logic d_oe_o
);
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ck_o && !d_oe_o));
  a_r12_busy_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  a_r12_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r13_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r14_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ck_o) |-> ($stable(d_oe_o) && $stable(d_o)));
  a_r14_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ck_o && !$past(ck_o)) |-> ($stable(d_oe_o) && $stable(d_o)));
endmodule

bind twd_master twd_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .ck_o(ck_o), .d_o(d_o), .d_oe_o(d_oe_o)
);

// File: tb/sim_twd_master.sv
`timescale 1ns/1ps
module sim_twd_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, d_in = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] wdata = '0, div = '0;
  logic busy, done, err, ck, d_out, d_oe;
  logic [7:0] rdata;

  always #2.5 clk = ~clk;

  twd_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .wdata_i(wdata),
    .div_i(div), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
    .ck_o(ck), .d_o(d_out), .d_oe_o(d_oe), .d_i(d_in)
  );

  int total = 0, fails = 0, cyc = 0;
  int n_exp, cap_n, lowcnt;
  bit exp_oe[64], exp_d[64], resp[64];
  bit cap_oe[64], cap_d[64], fall_oe[64], fall_d[64];
  int low_w[64];
  bit exp_err;
  logic [7:0] last_rd = '0;

  task automatic chk(string tag, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(bit oe, bit dv, bit r);
    exp_oe[n_exp] = oe; exp_d[n_exp] = dv; resp[n_exp] = r; n_exp++;
  endtask

  // expected wire sequence for one operation
  task automatic build(int o, logic [7:0] wd, logic [7:0] rd, int stall);
    n_exp = 0; exp_err = 0;
    for (int i = 0; i < 64; i++) resp[i] = 0;
    if (o >= 4) begin push(0, 0, 0); return; end
    push(0, 0, 0);
    push(1, o[0], 0); push(1, o[1], 0);
    if (o < 2) begin push(1, 0, 0); push(1, 0, 0); end
    if (o == 1 || o == 3) for (int i = 0; i < 8; i++) push(1, wd[i], 0);
    if (o == 2) for (int i = 0; i < 8; i++) push(0, 0, rd[i]);
    if (o < 2) begin
      for (int t = 0; t < 20; t++) begin
        push(0, 0, t == stall);
        if (t == stall) break;
      end
      if (stall >= 20) begin exp_err = 1; return; end
    end
    if (o == 0) for (int i = 0; i < 8; i++) push(0, 0, rd[i]);
    push(0, 0, 0);
  endtask

  always @(negedge clk) if (!ck) lowcnt++;
  always @(negedge ck) begin
    if (cap_n < 64) begin
      fall_oe[cap_n] = d_oe; fall_d[cap_n] = d_out;
      d_in <= resp[cap_n];
    end
  end
  always @(posedge ck) begin
    if (cap_n < 64) begin
      cap_oe[cap_n] = d_oe; cap_d[cap_n] = d_out; low_w[cap_n] = lowcnt;
    end
    cap_n++;
    lowcnt = 0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic run(int o, logic [7:0] wd, logic [7:0] rd, int stall, int dv, bit poke);
    string tag;
    bit ok;
    int t;
    tag = o >= 4 ? "R11" : o == 3 ? "R3" : o == 2 ? "R4" : o == 1 ? "R6" : "R7";
    build(o, wd, rd, stall);
    @(negedge clk);
    cap_n = 0; lowcnt = 0; div = 8'(dv);
    op = 3'(o); wdata = wd; start = 1;
    @(negedge clk); start = 0;
    chk("R12", busy === 1'b1, busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      op = 3'd4; wdata = ~wd; start = 1;
      @(negedge clk); start = 0;
    end
    t = 0;
    while (done !== 1'b1 && t < 4000) begin @(negedge clk); t++; end
    chk("R13", done === 1'b1, done, 1);
    chk(exp_err ? "R9" : "R8", err === exp_err, err, exp_err);
    if (o == 0 || o == 2) begin if (!exp_err) last_rd = rd; end
    chk(o == 0 ? "R7" : o == 2 ? "R4" : "R13", rdata === last_rd, rdata, last_rd);
    chk(poke ? "R12" : tag, cap_n == n_exp, cap_n, n_exp);
    ok = 1;
    for (int i = 0; i < n_exp && i < 64; i++)
      if (cap_oe[i] != exp_oe[i] || (exp_oe[i] && cap_d[i] != exp_d[i])) ok = 0;
    chk(tag, ok, cap_n, n_exp);
    if (o < 4)
      chk("R2", cap_oe[0] == 0 && cap_oe[1] && cap_oe[2] && cap_d[1] == o[0] && cap_d[2] == o[1],
          {cap_d[2], cap_d[1]}, o & 3);
    if (o < 2) chk("R5", cap_oe[3] && cap_oe[4] && !cap_d[3] && !cap_d[4], {cap_d[4], cap_d[3]}, 0);
    ok = 1;
    for (int i = 0; i < n_exp && i < 64; i++)
      if (fall_oe[i] != cap_oe[i] || fall_d[i] != cap_d[i]) ok = 0;
    chk("R14", ok, 0, 0);
    if (o >= 4) chk("R11", low_w[0] == 25 * (dv + 1), low_w[0], 25 * (dv + 1));
    else begin
      ok = 1;
      for (int i = 0; i < n_exp && i < 64; i++) if (low_w[i] != dv + 1) ok = 0;
      chk("R10", ok, low_w[0], dv + 1);
    end
    @(negedge clk);
    chk("R13", done === 1'b0 && busy === 1'b0, done, 0);
    chk("R1", ck === 1'b1 && d_oe === 1'b0, d_oe, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", ck === 1'b1 && d_oe === 1'b0 && busy === 1'b0 && done === 1'b0, busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // directed corners
    run(3, 8'hA5, 8'h00, 0, 0, 0);
    run(2, 8'h00, 8'h3C, 0, 1, 0);
    run(1, 8'h81, 8'h00, 19, 1, 0);
    run(0, 8'h00, 8'hC6, 19, 2, 0);
    run(0, 8'h00, 8'h55, 20, 1, 0);
    run(1, 8'h7E, 8'h00, 22, 0, 0);
    run(4, 8'h00, 8'h00, 0, 1, 0);
    run(7, 8'h00, 8'h00, 0, 0, 0);
    run(3, 8'h12, 8'h00, 0, 2, 1);
    run(0, 8'h00, 8'h9A, 3, 1, 1);
    for (int k = 0; k < 30; k++)
      run(int'($urandom_range(0, 4)), 8'($urandom), 8'($urandom),
          int'($urandom_range(0, 22)), int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule